// File: doc/BRIEF.md
# Nibble-Indexed Bank and Mirroring Controller

This block is the address-translation core of a cartridge memory mapper for an 8-bit console. The CPU reaches it by writing into the upper half of its address space. One write picks a target register through a 4-bit index. A second write loads that register with a bank number. The block holds eight 1 KB pattern-bank registers for the picture processor and four 8 KB program-bank registers for the CPU. It also holds the nametable mirroring mode.

From these registers the block forms two addresses. The first is a program ROM address for the 8 KB CPU window that is being accessed. The second is a pattern address for the 1 KB picture-processor window that is being fetched. It also raises a flag that steers a pattern fetch to on-cartridge character RAM when the bank number is small, or to character ROM otherwise. Both translations are combinational from the registers, so a register write takes effect for the first access after the write edge.

Top module: `nibble_bank_ctrl`

## Requirements
- R1: A write is decoded from `cpu_addr & 16'hE001`. A masked value of 16'h8000 loads the index register. 16'h8001 loads the register that the index selects. 16'hA000 loads the mirroring mode. Any other masked value, including every address below 16'h8000, changes nothing.
- R2: Index values 0 to 7 (the low nibble of the index register) direct a data write to pattern-bank register 0 to 7.
- R3: Index values 8 to 11 direct a data write to program-bank register 0 to 3. Index values 12 to 15 make the data write change nothing.
- R4: When bit 7 of the index register is set, pattern window w uses pattern-bank register w XOR 4. When bit 7 is clear, pattern window w uses register w.
- R5: `chr_is_ram` is 1 when the selected pattern-bank value is 7 or less, and 0 when it is larger.
- R6: After reset, pattern-bank register i holds i, and the program banks hold 0, 1, PRG_BANKS-2 and PRG_BANKS-1. The index register is 0 and the mirroring mode is 0.
- R7: `mirror_mode` is set from bits 1:0 of the data written to the mirroring address: 0 is vertical, 1 is horizontal, 2 is a single screen on the lower table, and 3 is a single screen on the upper table.
- R8: `prg_rom_addr` = {program bank[`cpu_addr[14:13]`], `cpu_addr[12:0]`}. The bank value is the written data truncated to log2(PRG_BANKS) bits.
- R9: `chr_addr` = {pattern bank of window `ppu_addr[12:10]`, `ppu_addr[9:0]`}. The window is chosen as R4 describes.
- R10: A register write at a clock edge is visible on the outputs right after that edge. With no write, the outputs depend only on the current addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU address for writes and program translation |
| cpu_wdata | input | 8 | CPU write data |
| ppu_addr | input | 13 | Pattern-space fetch address |
| prg_rom_addr | output | PRG_W+13 | Translated program ROM byte address |
| chr_addr | output | CHR_W+10 | Translated pattern byte address |
| chr_is_ram | output | 1 | Pattern fetch goes to character RAM |
| mirror_mode | output | 2 | Nametable mirroring mode |

## Verification
The outputs are combinational from the registers, so a wrong register value appears in the cycle after the faulty write. It shows only when an access falls in a window that uses that register. A wrong index or a lost inversion bit shows up only as the wrong bank in some windows. For that reason, every window of both address spaces is swept after each write. A decode that wrongly lets a write through shows as a changed bank or mirroring mode on the next sweep.

// File: rtl/nbc_pkg.sv
package nbc_pkg;

    localparam int unsigned CHR_SLOTS = 8;
    localparam int unsigned PRG_SLOTS = 4;

    localparam logic [15:0] DEC_MASK  = 16'hE001;
    localparam logic [15:0] HIT_INDEX = 16'h8000;
    localparam logic [15:0] HIT_BANK  = 16'h8001;
    localparam logic [15:0] HIT_MIRR  = 16'hA000;

    typedef enum logic [1:0] {
        MIR_VERT   = 2'd0,
        MIR_HORZ   = 2'd1,
        MIR_ONE_LO = 2'd2,
        MIR_ONE_HI = 2'd3
    } mirror_e;

    typedef enum logic [1:0] {
        WR_NONE,
        WR_INDEX,
        WR_BANK,
        WR_MIRR
    } wr_kind_e;

    function automatic wr_kind_e classify(input logic [15:0] a);
        logic [15:0] m;
        m = a & DEC_MASK;
        if (m == HIT_INDEX)     return WR_INDEX;
        else if (m == HIT_BANK) return WR_BANK;
        else if (m == HIT_MIRR) return WR_MIRR;
        else                    return WR_NONE;
    endfunction

endpackage

// File: rtl/nbc_regs.sv
module nbc_regs
    import nbc_pkg::*;
#(
    parameter int unsigned PRG_BANKS = 64,
    parameter int unsigned PRG_W     = 6,
    parameter int unsigned CHR_W     = 8
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                wr,
    input  logic [15:0]                         addr,
    input  logic [7:0]                          wdata,
    output logic [CHR_SLOTS-1:0][CHR_W-1:0]     chr_bank,
    output logic [PRG_SLOTS-1:0][PRG_W-1:0]     prg_bank,
    output logic                                invert,
    output mirror_e                             mirror
);

    logic [7:0] index_q;
    wr_kind_e   kind;

    assign kind   = wr ? classify(addr) : WR_NONE;
    assign invert = index_q[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            index_q <= '0;
            mirror  <= MIR_VERT;
            for (int i = 0; i < CHR_SLOTS; i++) begin
                chr_bank[i] <= CHR_W'(i);
            end
            prg_bank[0] <= PRG_W'(0);
            prg_bank[1] <= PRG_W'(1);
            prg_bank[2] <= PRG_W'(PRG_BANKS - 2);
            prg_bank[3] <= PRG_W'(PRG_BANKS - 1);
        end else begin
            case (kind)
                WR_INDEX: index_q <= wdata;
                WR_MIRR:  mirror  <= mirror_e'(wdata[1:0]);
                WR_BANK: begin
                    if (!index_q[3]) begin
                        chr_bank[index_q[2:0]] <= wdata[CHR_W-1:0];
                    end else if (!index_q[2]) begin
                        prg_bank[index_q[1:0]] <= wdata[PRG_W-1:0];
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/nbc_prg_map.sv
module nbc_prg_map
    import nbc_pkg::*;
#(
    parameter int unsigned PRG_W = 6
) (
    input  logic [PRG_SLOTS-1:0][PRG_W-1:0] prg_bank,
    input  logic [15:0]                     cpu_addr,
    output logic [PRG_W+12:0]               prg_rom_addr
);

    logic [1:0] win;

    assign win          = cpu_addr[14:13];
    assign prg_rom_addr = {prg_bank[win], cpu_addr[12:0]};

endmodule

// File: rtl/nbc_chr_map.sv
module nbc_chr_map
    import nbc_pkg::*;
#(
    parameter int unsigned CHR_W = 8
) (
    input  logic [CHR_SLOTS-1:0][CHR_W-1:0] chr_bank,
    input  logic                            invert,
    input  logic [12:0]                     ppu_addr,
    output logic [CHR_W+9:0]                chr_addr,
    output logic                            chr_is_ram
);

    logic [CHR_SLOTS-1:0][CHR_W-1:0] win_bank;
    logic [CHR_SLOTS-1:0]            win_ram;
    logic [2:0]                      slot;

    for (genvar w = 0; w < CHR_SLOTS; w++) begin : g_win
        localparam logic [2:0] WIN = 3'(w);
        assign win_bank[w] = chr_bank[WIN ^ {invert, 2'b00}];
        assign win_ram[w]  = (win_bank[w] <= CHR_W'(7));
    end

    assign slot       = ppu_addr[12:10];
    assign chr_addr   = {win_bank[slot], ppu_addr[9:0]};
    assign chr_is_ram = win_ram[slot];

endmodule

// File: rtl/nibble_bank_ctrl.sv
module nibble_bank_ctrl
    import nbc_pkg::*;
#(
    parameter int unsigned PRG_BANKS = 64,
    parameter int unsigned CHR_W     = 8,
    localparam int unsigned PRG_W    = (PRG_BANKS > 1) ? $clog2(PRG_BANKS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_wr,
    input  logic [15:0]        cpu_addr,
    input  logic [7:0]         cpu_wdata,
    input  logic [12:0]        ppu_addr,
    output logic [PRG_W+12:0]  prg_rom_addr,
    output logic [CHR_W+9:0]   chr_addr,
    output logic               chr_is_ram,
    output logic [1:0]         mirror_mode
);

    logic [CHR_SLOTS-1:0][CHR_W-1:0] chr_bank;
    logic [PRG_SLOTS-1:0][PRG_W-1:0] prg_bank;
    logic                            invert;
    mirror_e                         mirror;

    nbc_regs #(
        .PRG_BANKS(PRG_BANKS),
        .PRG_W    (PRG_W),
        .CHR_W    (CHR_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (cpu_wr),
        .addr    (cpu_addr),
        .wdata   (cpu_wdata),
        .chr_bank(chr_bank),
        .prg_bank(prg_bank),
        .invert  (invert),
        .mirror  (mirror)
    );

    nbc_prg_map #(.PRG_W(PRG_W)) u_prg (
        .prg_bank    (prg_bank),
        .cpu_addr    (cpu_addr),
        .prg_rom_addr(prg_rom_addr)
    );

    nbc_chr_map #(.CHR_W(CHR_W)) u_chr (
        .chr_bank  (chr_bank),
        .invert    (invert),
        .ppu_addr  (ppu_addr),
        .chr_addr  (chr_addr),
        .chr_is_ram(chr_is_ram)
    );

    assign mirror_mode = mirror;

endmodule

// File: rtl/nbc_chk.sv
module nbc_chk #(
    parameter int unsigned PRG_W = 6,
    parameter int unsigned CHR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_wr,
    input logic [15:0]       cpu_addr,
    input logic [7:0]        cpu_wdata,
    input logic [12:0]       ppu_addr,
    input logic [PRG_W+12:0] prg_rom_addr,
    input logic [CHR_W+9:0]  chr_addr,
    input logic              chr_is_ram,
    input logic [1:0]        mirror_mode
);

    logic wr_mirr;
    assign wr_mirr = cpu_wr && ((cpu_addr & 16'hE001) == 16'hA000);

    // R7
    mirror_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_mirr |=> mirror_mode == $past(cpu_wdata[1:0]));

    // R1
    mirror_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_mirr |=> $stable(mirror_mode));

    // R5
    ram_route_chk: assert property (@(posedge clk) disable iff (rst)
        chr_is_ram == (chr_addr[CHR_W+9:10] <= CHR_W'(7)));

    // R10
    chr_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(cpu_wr) && $stable(ppu_addr)) |-> ($stable(chr_addr) && $stable(chr_is_ram)));

    // R10
    prg_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(cpu_wr) && $stable(cpu_addr)) |-> $stable(prg_rom_addr));

endmodule

bind nibble_bank_ctrl nbc_chk #(.PRG_W(PRG_W), .CHR_W(CHR_W)) u_nbc_chk (
    .clk         (clk),
    .rst         (rst),
    .cpu_wr      (cpu_wr),
    .cpu_addr    (cpu_addr),
    .cpu_wdata   (cpu_wdata),
    .ppu_addr    (ppu_addr),
    .prg_rom_addr(prg_rom_addr),
    .chr_addr    (chr_addr),
    .chr_is_ram  (chr_is_ram),
    .mirror_mode (mirror_mode)
);

// File: tb/test_nibble_bank_ctrl.sv
`timescale 1ns/1ps
module test_nibble_bank_ctrl;

    localparam int PRG_BANKS = 64;
    localparam int PRG_W     = 6;
    localparam int CHR_W     = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cpu_wr = 1'b0;
    logic [15:0]       cpu_addr = '0;
    logic [7:0]        cpu_wdata = '0;
    logic [12:0]       ppu_addr = '0;
    logic [PRG_W+12:0] prg_rom_addr;
    logic [CHR_W+9:0]  chr_addr;
    logic              chr_is_ram;
    logic [1:0]        mirror_mode;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_chr [8];
    logic [7:0] m_prg [4];
    logic [7:0] m_idx;
    logic [1:0] m_mir;

    always #2.5 clk = ~clk;

    nibble_bank_ctrl #(.PRG_BANKS(PRG_BANKS), .CHR_W(CHR_W)) i_nibble_bank_ctrl (
        .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .ppu_addr(ppu_addr), .prg_rom_addr(prg_rom_addr),
        .chr_addr(chr_addr), .chr_is_ram(chr_is_ram), .mirror_mode(mirror_mode)
    );

    function automatic logic [PRG_W+12:0] exp_prg(input logic [15:0] a);
        logic [7:0] b;
        b = m_prg[a[14:13]];
        return {b[PRG_W-1:0], a[12:0]};
    endfunction

    function automatic logic [7:0] exp_bank(input logic [12:0] p);
        logic [2:0] w;
        w = p[12:10] ^ (m_idx[7] ? 3'd4 : 3'd0);
        return m_chr[w];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_chr[i] = 8'(i);
        m_prg[0] = 8'd0; m_prg[1] = 8'd1;
        m_prg[2] = 8'(PRG_BANKS - 2); m_prg[3] = 8'(PRG_BANKS - 1);
        m_idx = 8'd0; m_mir = 2'd0;
    endtask

    task automatic write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
        case (a & 16'hE001)
            16'h8000: m_idx = d;
            16'h8001: begin
                if (m_idx[3:0] < 4'd8)       m_chr[m_idx[2:0]] = d;
                else if (m_idx[3:0] < 4'd12) m_prg[m_idx[1:0]] = d;
            end
            16'hA000: m_mir = d[1:0];
            default: ;
        endcase
    endtask

    // Sweeps every program and pattern window at the current model state.
    task automatic sweep(input string req);
        for (int w = 0; w < 4; w++) begin
            cpu_addr = {1'b1, 2'(w), 13'($urandom)};
            #0.5;
            check({req, " R8 prg"}, 32'(prg_rom_addr), 32'(exp_prg(cpu_addr)));
        end
        for (int s = 0; s < 8; s++) begin
            logic [7:0] b;
            ppu_addr = {3'(s), 10'($urandom)};
            #0.5;
            b = exp_bank(ppu_addr);
            check({req, " R9 chr"}, 32'(chr_addr), 32'({b[CHR_W-1:0], ppu_addr[9:0]}));
            check({req, " R5 ram"}, 32'(chr_is_ram), 32'(b <= 8'd7));
        end
        check({req, " R7 mirror"}, 32'(mirror_mode), 32'(m_mir));
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] a;
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        sweep("R6 reset");

        // R2 each pattern register, R10 visible at once
        for (int i = 0; i < 8; i++) begin
            write(16'h8000, 8'(i));
            write(16'h8001, 8'(8'h20 + i));
            sweep("R2 R10");
        end
        // R4 inversion
        write(16'h8000, 8'h80);
        sweep("R4 invert");
        // R3 program registers, masking by R8
        for (int i = 0; i < 4; i++) begin
            write(16'h8000, 8'(8 + i));
            write(16'h8001, 8'(8'hC0 | (i * 5)));
            sweep("R3 prg");
        end
        // R3 ignored indices 12..15
        for (int i = 12; i < 16; i++) begin
            write(16'h8000, 8'(i));
            write(16'h8001, 8'h3A);
            sweep("R3 ignored");
        end
        // R5 boundary 7 / 8
        write(16'h8000, 8'h00); write(16'h8001, 8'h07);
        write(16'h8000, 8'h01); write(16'h8001, 8'h08);
        sweep("R5 boundary");
        // R7 all modes
        for (int i = 0; i < 4; i++) begin
            write(16'hA000, 8'(8'hFC | i));
            sweep("R7 modes");
        end
        // R1 aliases and non-decoded addresses
        write(16'h9FFE, 8'h05);            // alias of index reg
        write(16'hBFFF, 8'h02);            // masked to A001: ignored
        write(16'h9F11, 8'h11);            // alias of bank data
        write(16'h6001, 8'hFF);            // below 0x8000: ignored
        write(16'hC000, 8'hFF);            // ignored
        write(16'hE001, 8'hFF);            // ignored
        sweep("R1 decode");
        // Random mix
        for (int n = 0; n < 400; n++) begin
            case ($urandom % 5)
                0: a = 16'h8000 | (16'($urandom) & 16'h1FFE);
                1, 2: a = 16'h8001 | (16'($urandom) & 16'h1FFE);
                3: a = 16'hA000 | (16'($urandom) & 16'h1FFE);
                default: a = 16'($urandom);
            endcase
            write(a, 8'($urandom));
            sweep("R1 random");
        end
        // reset again returns defaults
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        model_reset();
        sweep("R6 re-reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule